// File: doc/BRIEF.md
# Banked General-Purpose Register File

This block holds the sixteen 32-bit general-purpose registers of a processor core. Registers 0 to 7 are kept in two physical copies, bank 0 and bank 1; registers 8 to 15 exist once and are shared. The normal operand ports use a *working bank* for registers 0 to 7. These are two combinational read ports and one clocked write port. A separate transfer port reaches the other bank, the *shadow bank*. Control-register move instructions use it to save or restore the registers of the mode that is not active.

The working bank depends on two inputs taken from the status register: a privilege-mode bit and a bank-select bit. In user mode the bank-select bit is ignored and bank 0 is always the working bank. In privileged mode the bank-select bit picks the working bank. Both bits are registered inside the block, so a change applies to operand accesses from the next cycle on. No register contents are lost when the banks swap.

A transfer-port request made while the block is in user mode is refused. Nothing is written, the read data is zero, and a fault flag goes high in that same cycle. All ports are plain single-cycle register-file ports, with no valid/ready handshake and no back-pressure. Every request is served in the cycle it is presented.

Top module: `banked_regfile`

## Requirements
- R1: A synchronous active-high reset clears all 24 physical entries to zero and sets user mode with bank-select 0. After reset every register reads zero on every read port.
- R2: Reads are combinational. A write on the normal port (`wr_en`=1) updates the addressed register at the rising edge. A read of that register in the same cycle still returns the old value.
- R3: The two read ports take independent 4-bit indices and return their registers' values in the same cycle.
- R4: Registers 8 to 15 are a single shared copy. Normal-port reads and writes of them are unaffected by mode or bank-select.
- R5: In user mode (`priv_mode`=0), bank-select is ignored and registers 0 to 7 on the normal ports map to bank 0.
- R6: In privileged mode (`priv_mode`=1), bank-select 0 makes bank 0 the working bank and bank-select 1 makes bank 1 the working bank.
- R7: The transfer port takes a 3-bit index and always addresses the shadow bank, the bank opposite the working bank. In privileged mode with `alt_en`=1, `alt_rdata` returns that entry, and `alt_we`=1 writes `alt_wdata` to it at the rising edge. With `alt_en`=0, `alt_rdata` is zero.
- R8: In user mode, `alt_en`=1 raises `priv_fault` for that cycle, forces `alt_rdata` to zero and suppresses any transfer-port write. In privileged mode `priv_fault` stays low.
- R9: A change of `priv_mode` or `bank_sel` takes effect for operand accesses and the fault check one cycle after it is presented. No register contents are lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| priv_mode | input | 1 | Mode from status register: 1 privileged, 0 user |
| bank_sel | input | 1 | Bank-select bit from status register |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Normal write enable |
| wr_idx | input | 4 | Normal write register index |
| wr_data | input | 32 | Normal write data |
| alt_en | input | 1 | Transfer-port request |
| alt_we | input | 1 | Transfer-port write (with alt_en) |
| alt_idx | input | 3 | Transfer-port index into the shadow bank |
| alt_wdata | input | 32 | Transfer-port write data |
| alt_rdata | output | 32 | Transfer-port read data |
| priv_fault | output | 1 | Transfer request refused in user mode |

## Verification
Three timings apply:
- Read data and the fault flag are due in the same cycle as the index or request that produces them.
- A write is due on the read ports only after the next rising edge.
- A mode or bank-select change shows up one rising edge after it is presented.

The bench applies each stimulus on the falling edge and samples 4 ns later, before the rising edge. So every sample reflects the state left by the previous edge together with the current inputs. The vector table is laid out so that each write or mode change is checked first as not yet visible and then, in the next row, as visible.

// File: rtl/brf_pkg.sv
package brf_pkg;

  typedef enum logic {
    BANK_LO = 1'b0,
    BANK_HI = 1'b1
  } bank_e;

  // Physical slot numbering: bank 0 copies first, bank 1 copies next,
  // shared registers last. Banked index i of bank b -> i + b*nb,
  // unbanked index i -> i + nb.
  function automatic int unsigned slot_of(int unsigned idx, logic bank,
                                          int unsigned nb);
    if (idx < nb) begin
      return bank ? (idx + nb) : idx;
    end
    return idx + nb;
  endfunction

endpackage

// File: rtl/brf_mode_track.sv
module brf_mode_track (
  input  logic clk,
  input  logic rst,
  input  logic priv_mode,
  input  logic bank_sel,
  output logic priv_q,
  output logic work_bank,
  output logic shadow_bank
);
  import brf_pkg::*;

  logic  priv_r;
  logic  sel_r;
  bank_e work_e;

  always_ff @(posedge clk) begin
    if (rst) begin
      priv_r <= 1'b0;
      sel_r  <= 1'b0;
    end else begin
      priv_r <= priv_mode;
      sel_r  <= bank_sel;
    end
  end

  // User mode pins the working bank to bank 0.
  always_comb begin
    if (priv_r && sel_r) work_e = BANK_HI;
    else                 work_e = BANK_LO;
  end

  assign priv_q      = priv_r;
  assign work_bank   = work_e;
  assign shadow_bank = ~work_e;

endmodule

// File: rtl/brf_storage.sv
module brf_storage #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_PHYS = 24,
  parameter int unsigned PHYS_W   = $clog2(NUM_PHYS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              n_we,
  input  logic [PHYS_W-1:0] n_slot,
  input  logic [DATA_W-1:0] n_data,
  input  logic              s_we,
  input  logic [PHYS_W-1:0] s_slot,
  input  logic [DATA_W-1:0] s_data,
  output logic [DATA_W-1:0] slots [NUM_PHYS]
);

  for (genvar p = 0; p < NUM_PHYS; p++) begin : g_slot
    logic              hit_n;
    logic              hit_s;
    logic [DATA_W-1:0] q;

    assign hit_n = n_we && (n_slot == PHYS_W'(p));
    assign hit_s = s_we && (s_slot == PHYS_W'(p));

    // Normal port has priority over the transfer port on one slot.
    always_ff @(posedge clk) begin
      if (rst) begin
        q <= '0;
      end else if (hit_n) begin
        q <= n_data;
      end else if (hit_s) begin
        q <= s_data;
      end
    end

    assign slots[p] = q;
  end

endmodule

// File: rtl/brf_read_port.sv
module brf_read_port #(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned NUM_PHYS   = 24,
  parameter int unsigned PHYS_W     = $clog2(NUM_PHYS),
  parameter int unsigned IDX_W      = 4,
  parameter int unsigned NUM_BANKED = 8
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic              bank,
  input  logic [DATA_W-1:0] slots [NUM_PHYS],
  output logic [DATA_W-1:0] data
);
  import brf_pkg::*;

  logic [PHYS_W-1:0] slot;

  assign slot = PHYS_W'(slot_of(32'(idx), bank, NUM_BANKED));

  always_comb begin
    data = '0;
    for (int p = 0; p < int'(NUM_PHYS); p++) begin
      if (slot == PHYS_W'(p)) data = slots[p];
    end
  end

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned NUM_REGS   = 16,
  parameter int unsigned NUM_BANKED = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          priv_mode,
  input  logic                          bank_sel,
  input  logic [$clog2(NUM_REGS)-1:0]   rd_a_idx,
  output logic [DATA_W-1:0]             rd_a_data,
  input  logic [$clog2(NUM_REGS)-1:0]   rd_b_idx,
  output logic [DATA_W-1:0]             rd_b_data,
  input  logic                          wr_en,
  input  logic [$clog2(NUM_REGS)-1:0]   wr_idx,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic                          alt_en,
  input  logic                          alt_we,
  input  logic [$clog2(NUM_BANKED)-1:0] alt_idx,
  input  logic [DATA_W-1:0]             alt_wdata,
  output logic [DATA_W-1:0]             alt_rdata,
  output logic                          priv_fault
);
  import brf_pkg::*;

  localparam int unsigned IDX_W    = $clog2(NUM_REGS);
  localparam int unsigned SIDX_W   = $clog2(NUM_BANKED);
  localparam int unsigned NUM_PHYS = NUM_REGS + NUM_BANKED;
  localparam int unsigned PHYS_W   = $clog2(NUM_PHYS);

  logic              priv_q;
  logic              work_bank;
  logic              shadow_bank;
  logic              alt_ok;
  logic              alt_wr_ok;
  logic [PHYS_W-1:0] wr_slot;
  logic [PHYS_W-1:0] alt_slot;
  logic [IDX_W-1:0]  alt_idx_ext;
  logic [DATA_W-1:0] alt_raw;
  logic [DATA_W-1:0] slots [NUM_PHYS];

  brf_mode_track u_mode (
    .clk         (clk),
    .rst         (rst),
    .priv_mode   (priv_mode),
    .bank_sel    (bank_sel),
    .priv_q      (priv_q),
    .work_bank   (work_bank),
    .shadow_bank (shadow_bank)
  );

  // Transfer port is honoured only in privileged mode.
  assign alt_ok     = alt_en && priv_q;
  assign alt_wr_ok  = alt_ok && alt_we;
  assign priv_fault = alt_en && !priv_q;

  assign alt_idx_ext = IDX_W'(alt_idx);
  assign wr_slot  = PHYS_W'(slot_of(32'(wr_idx), work_bank, NUM_BANKED));
  assign alt_slot = PHYS_W'(slot_of(32'(alt_idx_ext), shadow_bank, NUM_BANKED));

  brf_storage #(
    .DATA_W   (DATA_W),
    .NUM_PHYS (NUM_PHYS),
    .PHYS_W   (PHYS_W)
  ) u_store (
    .clk    (clk),
    .rst    (rst),
    .n_we   (wr_en),
    .n_slot (wr_slot),
    .n_data (wr_data),
    .s_we   (alt_wr_ok),
    .s_slot (alt_slot),
    .s_data (alt_wdata),
    .slots  (slots)
  );

  brf_read_port #(
    .DATA_W (DATA_W), .NUM_PHYS (NUM_PHYS), .PHYS_W (PHYS_W),
    .IDX_W  (IDX_W),  .NUM_BANKED (NUM_BANKED)
  ) u_rd_a (
    .idx   (rd_a_idx),
    .bank  (work_bank),
    .slots (slots),
    .data  (rd_a_data)
  );

  brf_read_port #(
    .DATA_W (DATA_W), .NUM_PHYS (NUM_PHYS), .PHYS_W (PHYS_W),
    .IDX_W  (IDX_W),  .NUM_BANKED (NUM_BANKED)
  ) u_rd_b (
    .idx   (rd_b_idx),
    .bank  (work_bank),
    .slots (slots),
    .data  (rd_b_data)
  );

  brf_read_port #(
    .DATA_W (DATA_W), .NUM_PHYS (NUM_PHYS), .PHYS_W (PHYS_W),
    .IDX_W  (IDX_W),  .NUM_BANKED (NUM_BANKED)
  ) u_rd_alt (
    .idx   (alt_idx_ext),
    .bank  (shadow_bank),
    .slots (slots),
    .data  (alt_raw)
  );

  assign alt_rdata = alt_ok ? alt_raw : '0;

endmodule

// File: rtl/brf_checker.sv
module brf_checker #(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned IDX_W      = 4,
  parameter int unsigned NUM_BANKED = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              priv_mode,
  input logic              bank_sel,
  input logic              priv_q,
  input logic              work_bank,
  input logic              alt_en,
  input logic              priv_fault,
  input logic [DATA_W-1:0] alt_rdata,
  input logic              wr_en,
  input logic [IDX_W-1:0]  rd_a_idx,
  input logic [DATA_W-1:0] rd_a_data
);

  p_fault_needs_request_r8: assert property (@(posedge clk) disable iff (rst)
    priv_fault |-> alt_en);

  p_user_request_refused_r8: assert property (@(posedge clk) disable iff (rst)
    (alt_en && !priv_q) |-> (priv_fault && alt_rdata == '0));

  p_priv_request_clean_r7: assert property (@(posedge clk) disable iff (rst)
    (alt_en && priv_q) |-> !priv_fault);

  p_user_bank_zero_r5: assert property (@(posedge clk) disable iff (rst)
    !priv_q |-> (work_bank == 1'b0));

  p_mode_one_cycle_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (priv_q == $past(priv_mode)));

  p_bank_follows_select_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(priv_mode)) |-> (work_bank == $past(bank_sel)));

  p_shared_stable_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_en) && $stable(rd_a_idx)
     && rd_a_idx >= IDX_W'(NUM_BANKED)) |-> $stable(rd_a_data));

endmodule

bind banked_regfile brf_checker #(
  .DATA_W     (DATA_W),
  .IDX_W      ($clog2(NUM_REGS)),
  .NUM_BANKED (NUM_BANKED)
) u_brf_checker (
  .clk        (clk),
  .rst        (rst),
  .priv_mode  (priv_mode),
  .bank_sel   (bank_sel),
  .priv_q     (priv_q),
  .work_bank  (work_bank),
  .alt_en     (alt_en),
  .priv_fault (priv_fault),
  .alt_rdata  (alt_rdata),
  .wr_en      (wr_en),
  .rd_a_idx   (rd_a_idx),
  .rd_a_data  (rd_a_data)
);

// File: tb/banked_regfile_tb.sv
module banked_regfile_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        priv_mode = 1'b0;
  logic        bank_sel = 1'b0;
  logic [3:0]  rd_a_idx = '0;
  logic [31:0] rd_a_data;
  logic [3:0]  rd_b_idx = '0;
  logic [31:0] rd_b_data;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic        alt_en = 1'b0;
  logic        alt_we = 1'b0;
  logic [2:0]  alt_idx = '0;
  logic [31:0] alt_wdata = '0;
  logic [31:0] alt_rdata;
  logic        priv_fault;

  int n_checks = 0;
  int n_fails  = 0;

  always #5 clk = ~clk;

  banked_regfile dut_i (
    .clk (clk), .rst (rst), .priv_mode (priv_mode), .bank_sel (bank_sel),
    .rd_a_idx (rd_a_idx), .rd_a_data (rd_a_data),
    .rd_b_idx (rd_b_idx), .rd_b_data (rd_b_data),
    .wr_en (wr_en), .wr_idx (wr_idx), .wr_data (wr_data),
    .alt_en (alt_en), .alt_we (alt_we), .alt_idx (alt_idx),
    .alt_wdata (alt_wdata), .alt_rdata (alt_rdata), .priv_fault (priv_fault)
  );

  typedef struct packed {
    logic        pm;
    logic        bs;
    logic        we;
    logic [3:0]  wi;
    logic [31:0] wd;
    logic        ae;
    logic        aw;
    logic [2:0]  ai;
    logic [31:0] ad;
    logic [3:0]  ra;
    logic [3:0]  rb;
    logic [31:0] ea;
    logic [31:0] eb;
    logic [31:0] ealt;
    logic        ef;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 14;
  // Each row: inputs held for one cycle; expectations sampled before the edge.
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b1,4'd3, 32'h0000_00A1,1'b0,1'b0,3'd0,32'h0,         4'd3, 4'd12,32'h0,        32'h0,        32'h0,        1'b0,8'd2}, // R2 old value
    '{1'b0,1'b1,1'b1,4'd12,32'h0000_0C12,1'b0,1'b0,3'd0,32'h0,         4'd3, 4'd12,32'h0000_00A1,32'h0,        32'h0,        1'b0,8'd2}, // R2 write seen
    '{1'b0,1'b1,1'b0,4'd0, 32'h0,        1'b1,1'b1,3'd3,32'hBAD0_0BAD, 4'd3, 4'd12,32'h0000_00A1,32'h0000_0C12,32'h0,        1'b1,8'd8}, // R8 refused
    '{1'b1,1'b0,1'b0,4'd0, 32'h0,        1'b0,1'b0,3'd0,32'h0,         4'd3, 4'd12,32'h0000_00A1,32'h0000_0C12,32'h0,        1'b0,8'd9}, // R9 not yet
    '{1'b1,1'b0,1'b0,4'd0, 32'h0,        1'b1,1'b1,3'd3,32'h0000_0B13, 4'd3, 4'd12,32'h0000_00A1,32'h0000_0C12,32'h0,        1'b0,8'd8}, // R8 no write landed
    '{1'b1,1'b1,1'b1,4'd3, 32'h0000_0D03,1'b1,1'b0,3'd3,32'h0,         4'd3, 4'd12,32'h0000_00A1,32'h0000_0C12,32'h0000_0B13,1'b0,8'd7}, // R7 shadow read
    '{1'b1,1'b1,1'b1,4'd5, 32'h0000_0E15,1'b1,1'b0,3'd3,32'h0,         4'd3, 4'd12,32'h0000_0B13,32'h0000_0C12,32'h0000_0D03,1'b0,8'd6}, // R6 bank 1
    '{1'b1,1'b0,1'b0,4'd0, 32'h0,        1'b1,1'b0,3'd5,32'h0,         4'd5, 4'd3, 32'h0000_0E15,32'h0000_0B13,32'h0,        1'b0,8'd9}, // R9 swap lag
    '{1'b1,1'b0,1'b0,4'd0, 32'h0,        1'b1,1'b0,3'd5,32'h0,         4'd5, 4'd3, 32'h0,        32'h0000_0D03,32'h0000_0E15,1'b0,8'd6}, // R6 bank 0
    '{1'b0,1'b1,1'b0,4'd0, 32'h0,        1'b1,1'b1,3'd5,32'h0000_0F77, 4'd3, 4'd12,32'h0000_0D03,32'h0000_0C12,32'h0000_0E15,1'b0,8'd9}, // R9 still priv
    '{1'b0,1'b1,1'b0,4'd0, 32'h0,        1'b1,1'b0,3'd5,32'h0,         4'd3, 4'd5, 32'h0000_0D03,32'h0,        32'h0,        1'b1,8'd5}, // R5 bank ignored
    '{1'b1,1'b1,1'b0,4'd0, 32'h0,        1'b0,1'b0,3'd0,32'h0,         4'd12,4'd15,32'h0000_0C12,32'h0,        32'h0,        1'b0,8'd4}, // R4 shared
    '{1'b1,1'b1,1'b0,4'd0, 32'h0,        1'b0,1'b0,3'd0,32'h0,         4'd5, 4'd3, 32'h0000_0F77,32'h0000_0B13,32'h0,        1'b0,8'd7}, // R7 write landed
    '{1'b1,1'b1,1'b0,4'd0, 32'h0,        1'b0,1'b0,3'd0,32'h0,         4'd12,4'd3, 32'h0000_0C12,32'h0000_0B13,32'h0,        1'b0,8'd4}  // R4 shared in bank 1
  };

  task automatic check32(input int req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL R%0d %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic idle_inputs();
    wr_en = 1'b0; alt_en = 1'b0; alt_we = 1'b0;
  endtask

  task automatic report_and_end();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    report_and_end();
  end

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;

    // R1: state after reset
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      rd_a_idx = 4'(i); rd_b_idx = 4'(15 - i);
      #4;
      check32(1, "reset rd_a", rd_a_data, 32'h0);
      check32(1, "reset rd_b", rd_b_data, 32'h0);
    end
    check32(1, "reset fault", {31'b0, priv_fault}, 32'h0);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      priv_mode = VECS[v].pm; bank_sel = VECS[v].bs;
      wr_en = VECS[v].we; wr_idx = VECS[v].wi; wr_data = VECS[v].wd;
      alt_en = VECS[v].ae; alt_we = VECS[v].aw; alt_idx = VECS[v].ai;
      alt_wdata = VECS[v].ad;
      rd_a_idx = VECS[v].ra; rd_b_idx = VECS[v].rb;
      #4;
      check32(int'(VECS[v].req), $sformatf("vec %0d rd_a", v), rd_a_data, VECS[v].ea);
      check32(int'(VECS[v].req), $sformatf("vec %0d rd_b", v), rd_b_data, VECS[v].eb);
      check32(int'(VECS[v].req), $sformatf("vec %0d alt_rdata", v), alt_rdata, VECS[v].ealt);
      check32(int'(VECS[v].req), $sformatf("vec %0d fault", v),
              {31'b0, priv_fault}, {31'b0, VECS[v].ef});
    end

    // R3 and R4: fill all sixteen in user mode, read back on both ports
    @(negedge clk);
    idle_inputs(); priv_mode = 1'b0; bank_sel = 1'b1;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 4'(i); wr_data = 32'h5A5A_0000 + 32'(i);
    end
    @(negedge clk);
    idle_inputs();
    @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      rd_a_idx = 4'(i); rd_b_idx = 4'(15 - i);
      #4;
      check32(3, "fill rd_a", rd_a_data, 32'h5A5A_0000 + 32'(i));
      check32(3, "fill rd_b", rd_b_data, 32'h5A5A_0000 + 32'(15 - i));
    end

    // R1: reset in mid-run clears everything
    @(negedge clk);
    rst = 1'b1; priv_mode = 1'b0; bank_sel = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      rd_a_idx = 4'(i);
      #4;
      check32(1, "re-reset rd_a", rd_a_data, 32'h0);
    end

    report_and_end();
  end

endmodule